// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns level signals from GPIO pins and from on-chip event sources into per-line interrupt requests for a processor's interrupt controller. Each GPIO line n listens to pin n of exactly one port, picked by a per-line selector. The remaining upper lines each follow one on-chip event input, such as a clock wakeup. A chosen edge on the selected source latches a sticky pending bit, and a masked, registered copy of that bit drives the request output.

Software programs the mask, the edge enables and the port selectors over a simple peripheral register bus, and it reads and clears the pending bits there. A pending bit that is never cleared keeps its request asserted, so a handler that does not clear its line is entered again at once. Clearing the bit is what drops the request.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset the mask (0x00), rising-enable (0x04), falling-enable (0x08) and pending (0x14) registers read 0, and every irq_o bit is 0. Bit n of each of these registers belongs to line n.
- R2: A low-to-high change on a GPIO line's selected pin, with its rising enable and mask bits at 1, sets its pending bit. The request goes high on the 4th rising clock edge after the pin changes: two synchronizer stages, the pending latch and the output register.
- R3: A high-to-low change on the selected pin, with its falling enable and mask bits at 1, sets its pending bit.
- R4: An edge whose direction is not enabled for that line leaves the pending bit at 0.
- R5: A line whose mask bit is 0 does not set its pending bit on an edge, and its request is 0 even while its pending bit is 1. The pending bit is kept.
- R6: A pending bit stays at 1 until a 1 is written to its position at 0x14; writing 0 to that position has no effect.
- R7: After a write-1 clear of a pending bit, the request for that line drops on the following rising clock edge.
- R8: When an enabled edge sets a line in the same cycle as a write-1 clear of that line, the pending bit ends at 1.
- R9: GPIO line n is driven only by pin n of the port chosen by its selector, the 4-bit slot at bits (n%8)*4 of the word at 0x20+4*(n/8); pin n of port p is gpio_i bit p*NUM_GPIO+n. Pins of other ports have no effect on the line.
- R10: Changing a line's selector to a port whose pin sits at a different level does not set the pending bit, with both edge directions enabled.
- R11: Line NUM_GPIO+k follows evt_i[k]; with EVT_SYNC=0 it skips the synchronizer, so its request goes high on the 2nd rising clock edge after the event input rises.
- R12: Lines latch, report and clear independently: a write-1 clear removes only the written bits and leaves the other pending bits and requests in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe, 0 for read |
| paddr | input | 8 | Byte address within the block |
| pwdata | input | 32 | Bus write data |
| prdata | output | 32 | Bus read data, valid during the access phase |
| gpio_i | input | NUM_PORTS*NUM_GPIO | Asynchronous pin levels, port p pin n at bit p*NUM_GPIO+n |
| evt_i | input | NUM_LINES-NUM_GPIO | On-chip event levels for the upper lines |
| irq_o | output | NUM_LINES | Registered interrupt requests, one per line |

## Verification
The bench builds the block with 8 lines, 6 of them GPIO, 4 ports and EVT_SYNC=0. The small widths keep every register bit and every line in plain view, and 4 ports exercise a selector field with more than one bit. The narrow configuration also leaves room for two event lines on the unsynchronized path, which brings its shorter latency into reach next to the two-stage GPIO path. With few lines, an exact clear colliding with a new edge, a selector switch between pins held at opposite levels, and overlapping pending lines can each be timed to the cycle.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;
   localparam int unsigned BUS_AW    = 8;
   localparam int unsigned BUS_DW    = 32;
   localparam int unsigned SLOT_W    = 4;
   localparam int unsigned SLOTS_PER = BUS_DW / SLOT_W;

   localparam logic [BUS_AW-1:0] OFS_MASK = 8'h00;
   localparam logic [BUS_AW-1:0] OFS_RISE = 8'h04;
   localparam logic [BUS_AW-1:0] OFS_FALL = 8'h08;
   localparam logic [BUS_AW-1:0] OFS_PEND = 8'h14;
   localparam logic [BUS_AW-1:0] OFS_SEL0 = 8'h20;

   function automatic logic [BUS_AW-1:0] sel_word_addr(input int unsigned line);
      return OFS_SEL0 + BUS_AW'(4 * (line / SLOTS_PER));
   endfunction
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta_q;
   logic [W-1:0] stab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         stab_q <= '0;
      end else begin
         meta_q <= d_i;
         stab_q <= meta_q;
      end
   end

   assign q_o = stab_q;
endmodule

// File: rtl/irq_line_regs.sv
module irq_line_regs
   import irq_line_pkg::*;
#(
   parameter int unsigned NUM_LINES = 23,
   parameter int unsigned NUM_GPIO  = 16,
   parameter int unsigned SEL_W     = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      psel,
   input  logic                      penable,
   input  logic                      pwrite,
   input  logic [BUS_AW-1:0]         paddr,
   input  logic [BUS_DW-1:0]         pwdata,
   output logic [BUS_DW-1:0]         prdata,
   input  logic [NUM_LINES-1:0]      pend_i,
   output logic [NUM_LINES-1:0]      mask_o,
   output logic [NUM_LINES-1:0]      rise_o,
   output logic [NUM_LINES-1:0]      fall_o,
   output logic [NUM_GPIO*SEL_W-1:0] sel_o,
   output logic [NUM_GPIO-1:0]       reload_o,
   output logic [NUM_LINES-1:0]      clr_o
);
   logic                      wr_en;
   logic [NUM_LINES-1:0]      mask_q, rise_q, fall_q;
   logic [NUM_GPIO*SEL_W-1:0] sel_q;
   logic [NUM_GPIO-1:0]       reload_q;
   logic                      bus_unused;

   assign wr_en      = psel & penable & pwrite;
   assign bus_unused = ^pwdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         rise_q   <= '0;
         fall_q   <= '0;
         sel_q    <= '0;
         reload_q <= '0;
      end else begin
         if (wr_en && paddr == OFS_MASK) mask_q <= pwdata[NUM_LINES-1:0];
         if (wr_en && paddr == OFS_RISE) rise_q <= pwdata[NUM_LINES-1:0];
         if (wr_en && paddr == OFS_FALL) fall_q <= pwdata[NUM_LINES-1:0];
         for (int g = 0; g < int'(NUM_GPIO); g++) begin
            if (wr_en && paddr == sel_word_addr(g)) begin
               sel_q[g*SEL_W +: SEL_W] <= pwdata[(g%SLOTS_PER)*SLOT_W +: SEL_W];
               reload_q[g] <= (pwdata[(g%SLOTS_PER)*SLOT_W +: SEL_W]
                               != sel_q[g*SEL_W +: SEL_W]);
            end else begin
               reload_q[g] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      prdata = '0;
      if (psel) begin
         unique case (paddr)
            OFS_MASK: prdata[NUM_LINES-1:0] = mask_q;
            OFS_RISE: prdata[NUM_LINES-1:0] = rise_q;
            OFS_FALL: prdata[NUM_LINES-1:0] = fall_q;
            OFS_PEND: prdata[NUM_LINES-1:0] = pend_i;
            default: begin
               for (int g = 0; g < int'(NUM_GPIO); g++) begin
                  if (paddr == sel_word_addr(g))
                     prdata[(g%SLOTS_PER)*SLOT_W +: SEL_W] = sel_q[g*SEL_W +: SEL_W];
               end
            end
         endcase
      end
   end

   assign clr_o    = (wr_en && paddr == OFS_PEND) ? pwdata[NUM_LINES-1:0] : '0;
   assign mask_o   = mask_q;
   assign rise_o   = rise_q;
   assign fall_o   = fall_q;
   assign sel_o    = sel_q;
   assign reload_o = reload_q;
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic reload_i,
   input  logic rise_en_i,
   input  logic fall_en_i,
   input  logic mask_i,
   input  logic clr_i,
   output logic pend_o,
   output logic irq_o
);
   logic prev_q, pend_q, irq_q;
   logic rise_w, fall_w, set_w;

   assign rise_w = src_i & ~prev_q;
   assign fall_w = ~src_i & prev_q;
   assign set_w  = mask_i & ~reload_i & ((rise_w & rise_en_i) | (fall_w & fall_en_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         prev_q <= src_i;
         pend_q <= set_w | (pend_q & ~clr_i);
         irq_q  <= pend_q & mask_i;
      end
   end

   assign pend_o = pend_q;
   assign irq_o  = irq_q;

   assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr_i) |=> pend_q);
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_w |=> pend_q);
   assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_i |=> !irq_q);
   assert_drop_after_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |=> !irq_q);
   assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
   import irq_line_pkg::*;
#(
   parameter int unsigned NUM_LINES = 23,
   parameter int unsigned NUM_GPIO  = 16,
   parameter int unsigned NUM_PORTS = 8,
   parameter bit          EVT_SYNC  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          psel,
   input  logic                          penable,
   input  logic                          pwrite,
   input  logic [7:0]                    paddr,
   input  logic [31:0]                   pwdata,
   output logic [31:0]                   prdata,
   input  logic [NUM_PORTS*NUM_GPIO-1:0] gpio_i,
   input  logic [NUM_LINES-NUM_GPIO-1:0] evt_i,
   output logic [NUM_LINES-1:0]          irq_o
);
   localparam int unsigned NUM_EVT = NUM_LINES - NUM_GPIO;
   localparam int unsigned NUM_PIN = NUM_PORTS * NUM_GPIO;
   localparam int unsigned SEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   initial begin
      assert (NUM_LINES <= BUS_DW) else $error("NUM_LINES exceeds bus width");
      assert (NUM_GPIO >= 1 && NUM_GPIO < NUM_LINES) else $error("bad NUM_GPIO");
      assert (NUM_PORTS >= 1 && NUM_PORTS <= (1 << SLOT_W)) else $error("bad NUM_PORTS");
   end

   logic [NUM_PIN-1:0]        gpio_s;
   logic [NUM_EVT-1:0]        evt_s;
   logic [NUM_LINES-1:0]      line_src, line_reload, mask, rise, fall, clr, pend;
   logic [NUM_GPIO*SEL_W-1:0] sel;
   logic [NUM_GPIO-1:0]       gpio_reload;

   irq_line_sync #(.W(NUM_PIN)) u_gpio_sync (
      .clk(clk), .rst_n(rst_n), .d_i(gpio_i), .q_o(gpio_s)
   );

   if (EVT_SYNC) begin : g_evt_sync
      irq_line_sync #(.W(NUM_EVT)) u_evt_sync (
         .clk(clk), .rst_n(rst_n), .d_i(evt_i), .q_o(evt_s)
      );
   end else begin : g_evt_direct
      assign evt_s = evt_i;
   end

   irq_line_regs #(
      .NUM_LINES(NUM_LINES), .NUM_GPIO(NUM_GPIO), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pend_i(pend), .mask_o(mask), .rise_o(rise), .fall_o(fall),
      .sel_o(sel), .reload_o(gpio_reload), .clr_o(clr)
   );

   for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio_mux
      always_comb begin
         line_src[g] = 1'b0;
         for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (sel[g*SEL_W +: SEL_W] == SEL_W'(p))
               line_src[g] = gpio_s[p*NUM_GPIO + g];
         end
      end
      assign line_reload[g] = gpio_reload[g];
   end

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt_line
      assign line_src[NUM_GPIO + e]    = evt_s[e];
      assign line_reload[NUM_GPIO + e] = 1'b0;
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_cell
      irq_line_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .src_i(line_src[n]), .reload_i(line_reload[n]),
         .rise_en_i(rise[n]), .fall_en_i(fall[n]),
         .mask_i(mask[n]), .clr_i(clr[n]),
         .pend_o(pend[n]), .irq_o(irq_o[n])
      );
   end

   assert_irq_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o & ~$past(pend)) == '0);
endmodule

// File: tb/tb_irq_line_ctrl.sv
module tb_irq_line_ctrl;
   localparam int NL = 8;
   localparam int NG = 6;
   localparam int NP = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]     paddr = '0;
   logic [31:0]    pwdata = '0;
   logic [31:0]    prdata;
   logic [NP*NG-1:0] gpio = '0;
   logic [NL-NG-1:0] evt = '0;
   logic [NL-1:0]  irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit ended = 0;

   typedef struct {
      logic [31:0]   data;
      logic [NL-1:0] irq;
      string         tag;
   } sb_item_t;
   sb_item_t sb[$];

   always #4 clk = ~clk;

   irq_line_ctrl #(.NUM_LINES(NL), .NUM_GPIO(NG), .NUM_PORTS(NP), .EVT_SYNC(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .gpio_i(gpio), .evt_i(evt), .irq_o(irq)
   );

   // Monitor: every read access phase is compared against the oldest expectation.
   always @(negedge clk) begin
      if (psel && penable && !pwrite) begin
         n_cmp++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL read with no expectation: got %h", prdata);
         end else begin
            sb_item_t it;
            it = sb.pop_front();
            if (prdata !== it.data || irq !== it.irq) begin
               n_bad++;
               $display("FAIL %s: got data %h irq %b, exp data %h irq %b",
                        it.tag, prdata, irq, it.data, it.irq);
            end
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(posedge clk); #1;
      penable = 1;
      @(posedge clk); #1;
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic expect_rd(input logic [7:0] a, input logic [31:0] d,
                            input logic [NL-1:0] ei, input string tag);
      sb_item_t it;
      it.data = d; it.irq = ei; it.tag = tag;
      sb.push_back(it);
      @(posedge clk); #1;
      psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(posedge clk); #1;
      penable = 1;
      @(posedge clk); #1;
      psel = 0; penable = 0;
   endtask

   task automatic check_bit(input logic got, input logic exp, input string tag);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b exp %b", tag, got, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(posedge clk);
      #1;
   endtask

   task automatic pin(input int port, input int n, input logic v);
      gpio[port*NG + n] = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset values
      expect_rd(8'h00, 32'h0, 8'h00, "R1 mask");
      expect_rd(8'h04, 32'h0, 8'h00, "R1 rise");
      expect_rd(8'h08, 32'h0, 8'h00, "R1 fall");
      expect_rd(8'h14, 32'h0, 8'h00, "R1 pend");

      // R2: rising edge and its latency
      bus_wr(8'h00, 32'hFF);
      bus_wr(8'h04, 32'h01);
      @(posedge clk); #1 pin(0, 0, 1);
      repeat (3) @(posedge clk);
      #4 check_bit(irq[0], 1'b0, "R2 irq before 4th edge");
      @(posedge clk); #4 check_bit(irq[0], 1'b1, "R2 irq at 4th edge");
      expect_rd(8'h14, 32'h01, 8'h01, "R2 pend set");

      // R6: sticky, write 0 ignored
      settle();
      expect_rd(8'h14, 32'h01, 8'h01, "R6 still pending");
      bus_wr(8'h14, 32'h00);
      settle();
      expect_rd(8'h14, 32'h01, 8'h01, "R6 write 0 no effect");

      // R7: clear drops request one edge later
      bus_wr(8'h14, 32'h01);
      #3 check_bit(irq[0], 1'b1, "R7 irq before next edge");
      @(posedge clk); #4 check_bit(irq[0], 1'b0, "R7 irq after next edge");
      expect_rd(8'h14, 32'h00, 8'h00, "R7 cleared");

      // R3 / R4: falling enable only on line 1, no enable on line 2
      bus_wr(8'h08, 32'h02);
      pin(0, 1, 1); pin(0, 2, 1);
      settle();
      expect_rd(8'h14, 32'h00, 8'h00, "R4 disabled edges");
      pin(0, 1, 0);
      settle();
      expect_rd(8'h14, 32'h02, 8'h02, "R3 falling edge");
      bus_wr(8'h14, 32'h02);

      // R5: masking
      bus_wr(8'h04, 32'h05);
      bus_wr(8'h00, 32'hFB);
      pin(0, 2, 0); settle(); pin(0, 2, 1); settle();
      expect_rd(8'h14, 32'h00, 8'h00, "R5 masked edge ignored");
      bus_wr(8'h00, 32'hFF);
      pin(0, 2, 0); settle(); pin(0, 2, 1); settle();
      expect_rd(8'h14, 32'h04, 8'h04, "R5 unmasked edge");
      bus_wr(8'h00, 32'hFB);
      settle();
      expect_rd(8'h14, 32'h04, 8'h00, "R5 mask hides request keeps pending");
      bus_wr(8'h00, 32'hFF);
      bus_wr(8'h14, 32'h04);
      settle();

      // R9: port select, line 3 from port 2
      bus_wr(8'h04, 32'h0D);
      bus_wr(8'h20, 32'h0000_2000);
      expect_rd(8'h20, 32'h0000_2000, 8'h00, "R9 select readback");
      pin(0, 3, 1);
      settle();
      expect_rd(8'h14, 32'h00, 8'h00, "R9 other port ignored");
      pin(2, 3, 1);
      settle();
      expect_rd(8'h14, 32'h08, 8'h08, "R9 selected port");
      bus_wr(8'h14, 32'h08);

      // R10: switching selector between opposite levels
      pin(2, 3, 0); pin(1, 3, 1);
      bus_wr(8'h08, 32'h0A);
      settle();
      bus_wr(8'h20, 32'h0000_1000);
      settle();
      expect_rd(8'h14, 32'h00, 8'h00, "R10 switch low to high");
      bus_wr(8'h20, 32'h0000_2000);
      settle();
      expect_rd(8'h14, 32'h00, 8'h00, "R10 switch high to low");

      // R8: new edge collides with clear
      bus_wr(8'h08, 32'h0B);
      pin(0, 0, 0);
      settle();
      expect_rd(8'h14, 32'h01, 8'h01, "R8 set before collision");
      @(posedge clk); #1 pin(0, 0, 1);
      bus_wr(8'h14, 32'h01);
      settle();
      expect_rd(8'h14, 32'h01, 8'h01, "R8 edge wins over clear");
      bus_wr(8'h14, 32'h01);
      settle();
      expect_rd(8'h14, 32'h00, 8'h00, "R8 plain clear");

      // R11: unsynchronized event line
      bus_wr(8'h04, 32'h4D);
      @(posedge clk); #1 evt[0] = 1;
      @(posedge clk); #4 check_bit(irq[6], 1'b0, "R11 irq before 2nd edge");
      @(posedge clk); #4 check_bit(irq[6], 1'b1, "R11 irq at 2nd edge");
      expect_rd(8'h14, 32'h40, 8'h40, "R11 event pending");

      // R12: independent lines
      bus_wr(8'h04, 32'hED);
      evt[1] = 1; pin(0, 5, 1);
      settle();
      expect_rd(8'h14, 32'hE0, 8'hE0, "R12 three pending");
      bus_wr(8'h14, 32'h80);
      settle();
      expect_rd(8'h14, 32'h60, 8'h60, "R12 partial clear");
      bus_wr(8'h14, 32'h60);
      settle();
      expect_rd(8'h14, 32'h00, 8'h00, "R12 all clear");

      settle();
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard left %0d items", sb.size());
      end
      finish_run();
   end
endmodule